// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This block is a barrel shifter that also produces the carry flag of a processor's shift and rotate operations. Each request carries an operand, a second operand for the double-precision shifts, a five-bit count, the incoming carry flag, an operation code and an operand-size code (8, 16 or 32 bits). The unit returns the shifted result, zero-extended to 32 bits, and the updated carry flag.

The supported operations are:

- logical left and right shifts, plus an arithmetic-left alias of the logical left shift;
- arithmetic right shift;
- plain rotates left and right;
- rotates through carry, which treat the carry flag as one extra bit above the operand;
- funnel shifts left and right, which take the vacated positions from the second operand.

The second operand is read only and is never written back.

Requests enter on a valid/ready stream and results leave on another valid/ready stream with a one-entry output register. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so the block sustains one operation per cycle when the consumer keeps `out_ready` high. When the consumer holds `out_ready` low, the pending result stays on the output unchanged and `in_ready` drops. The upstream side may change or drop its request while `in_ready` is low.

Top module: `srt_unit`

## Requirements
- R1: A request taken while `in_valid` and `in_ready` are high shows its result with `out_valid` high in the next cycle. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. After reset `out_valid` is low.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_res` and `out_cf` hold their values into the next cycle.
- R3: `in_size` selects the width w: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. Operand bits at and above w are ignored, and result bits at and above w are zero.
- R4: The count is the 5-bit `in_count` (0 to 31). A count of zero returns the operand (masked to w) and passes `in_cf` to `out_cf` for every operation.
- R5: Codes 0 and 9 shift left and fill with zeros. Carry is operand bit w-c, or 0 when c > w. For example, 8Fh by 1 at 8 bits gives 1Eh with carry 1.
- R6: Code 1 shifts right and fills with zeros. Carry is operand bit c-1, or 0 when c > w. For example, D0h by 1 gives 68h with carry 0.
- R7: Code 2 shifts right and fills with copies of the sign bit. Carry is operand bit c-1, or the sign bit when c > w. For example, F0h by 1 gives F8h.
- R8: Code 3 rotates left and code 4 rotates right, each by c mod w. Carry is result bit 0 for the left rotate and result bit w-1 for the right rotate.
- R9: Code 5 rotates left and code 6 rotates right the (w+1)-bit value {carry, operand} by c mod (w+1). The new top bit becomes the carry. For example, 88h with carry 0, rotated left once, gives 10h with carry 1, and a second left rotate gives 21h with carry 0.
- R10: Code 7 takes the top w bits of {a, b} shifted left by c, with zeros entering from below. Carry is the last bit to leave the top. For example, 9BA6h with AC36h by 4 at 16 bits gives BA6Ah with carry 1.
- R11: Code 8 takes the low w bits of {b, a} shifted right by c, with zeros entering from above. Carry is the last bit to leave the bottom. For example, 234Bh with 7654h by 4 gives 4234h with carry 1.
- R12: Codes 10 to 15 return the operand masked to w and pass `in_cf` through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_op | input | 4 | Operation code (see R5 to R12) |
| in_size | input | 2 | Operand width select |
| in_count | input | 5 | Shift or rotate count |
| in_a | input | 32 | Operand to be shifted |
| in_b | input | 32 | Fill operand for the funnel shifts |
| in_cf | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 32 | Result, zero above the operand width |
| out_cf | output | 1 | Updated carry flag |

## Verification
Every result is due exactly one clock after its request is taken and then stays on the output until the clock edge at which `out_ready` is high. The bench drives inputs on the falling edge. Shortly after that edge it samples both handshakes, which will take effect at the next rising edge. An accepted request queues its expected value, and each result that leaves is compared with the head of that queue. Under random back-pressure, a stalled result is also compared one cycle later with its previous value. The bench's expected values come from a bit-serial model that applies the count one step at a time.

// File: rtl/srt_pkg.sv
`timescale 1ns/1ps
package srt_pkg;
  // Operation codes; the values are visible at the block's port.
  typedef enum logic [3:0] {
    OP_SHL  = 4'd0,
    OP_SHR  = 4'd1,
    OP_SAR  = 4'd2,
    OP_ROL  = 4'd3,
    OP_ROR  = 4'd4,
    OP_RCL  = 4'd5,
    OP_RCR  = 4'd6,
    OP_SHLD = 4'd7,
    OP_SHRD = 4'd8,
    OP_SAL  = 4'd9
  } srt_op_e;
endpackage

// File: rtl/srt_lane.sv
`timescale 1ns/1ps
// One fixed-width datapath: all operations for operand width W.
module srt_lane
  import srt_pkg::*;
#(
  parameter int W     = 8,
  parameter int CNT_W = 5,
  parameter int OP_W  = 4
) (
  input  logic [OP_W-1:0]  op,
  input  logic [CNT_W-1:0] cnt,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             cin,
  output logic [W-1:0]     res,
  output logic             cf
);
  localparam int RW = $clog2(W);

  logic [W:0]       shl_v, shr_v, sar_v, shld_v, shrd_v, rcl_v, rcr_v, cyc_v;
  logic [W-1:0]     rol_v, ror_v;
  logic [RW-1:0]    rc;
  logic [CNT_W:0]   rcc;

  always_comb begin
    // Plain shifts: one guard bit catches the last bit shifted out.
    shl_v  = {1'b0, a} << cnt;
    shr_v  = {a, 1'b0} >> cnt;
    sar_v  = (W+1)'($signed({a, 1'b0}) >>> cnt);
    // Funnel shifts over the 2W-bit pair plus a guard bit.
    shld_v = (W+1)'(({1'b0, a, b} << cnt) >> W);
    shrd_v = (W+1)'({b, a, 1'b0} >> cnt);
    // Rotates within W bits.
    rc     = cnt[RW-1:0];
    rol_v  = (a << rc) | (a >> (W - int'(rc)));
    ror_v  = (a >> rc) | (a << (W - int'(rc)));
    // Rotates through carry over W+1 bits.
    cyc_v  = {cin, a};
    rcc    = (CNT_W+1)'(int'(cnt) % (W + 1));
    rcl_v  = (cyc_v << rcc) | (cyc_v >> (W + 1 - int'(rcc)));
    rcr_v  = (cyc_v >> rcc) | (cyc_v << (W + 1 - int'(rcc)));
  end

  always_comb begin
    res = a;
    cf  = cin;
    if (cnt != '0) begin
      case (op)
        OP_SHL, OP_SAL: begin res = shl_v[W-1:0];  cf = shl_v[W];   end
        OP_SHR:         begin res = shr_v[W:1];    cf = shr_v[0];   end
        OP_SAR:         begin res = sar_v[W:1];    cf = sar_v[0];   end
        OP_ROL:         begin res = rol_v;         cf = rol_v[0];   end
        OP_ROR:         begin res = ror_v;         cf = ror_v[W-1]; end
        OP_RCL:         begin res = rcl_v[W-1:0];  cf = rcl_v[W];   end
        OP_RCR:         begin res = rcr_v[W-1:0];  cf = rcr_v[W];   end
        OP_SHLD:        begin res = shld_v[W-1:0]; cf = shld_v[W];  end
        OP_SHRD:        begin res = shrd_v[W:1];   cf = shrd_v[0];  end
        default:        begin res = a;             cf = cin;        end
      endcase
    end
  end
endmodule

// File: rtl/srt_hold.sv
`timescale 1ns/1ps
// One-entry output register with valid/ready on both sides.
module srt_hold #(
  parameter int DW = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/srt_unit.sv
`timescale 1ns/1ps
module srt_unit #(
  parameter int BASE_W  = 8,
  parameter int NUM_SZ  = 3,
  parameter int CNT_W   = 5,
  parameter int OP_W    = 4,
  parameter int SZ_W    = 2,
  localparam int MAX_W  = BASE_W << (NUM_SZ - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OP_W-1:0]  in_op,
  input  logic [SZ_W-1:0]  in_size,
  input  logic [CNT_W-1:0] in_count,
  input  logic [MAX_W-1:0] in_a,
  input  logic [MAX_W-1:0] in_b,
  input  logic             in_cf,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MAX_W-1:0] out_res,
  output logic             out_cf
);
  localparam int DW = MAX_W + 1;

  logic [MAX_W-1:0] lane_res [NUM_SZ];
  logic             lane_cf  [NUM_SZ];

  for (genvar i = 0; i < NUM_SZ; i++) begin : g_lane
    localparam int W = BASE_W << i;
    logic [W-1:0] r;
    srt_lane #(.W(W), .CNT_W(CNT_W), .OP_W(OP_W)) i_lane (
      .op  (in_op),
      .cnt (in_count),
      .a   (in_a[W-1:0]),
      .b   (in_b[W-1:0]),
      .cin (in_cf),
      .res (r),
      .cf  (lane_cf[i])
    );
    assign lane_res[i] = MAX_W'(r);
  end

  // Size codes beyond the last lane select the widest lane.
  logic [MAX_W-1:0] sel_res;
  logic             sel_cf;
  always_comb begin
    sel_res = lane_res[NUM_SZ-1];
    sel_cf  = lane_cf[NUM_SZ-1];
    for (int i = 0; i < NUM_SZ - 1; i++) begin
      if (int'(in_size) == i) begin
        sel_res = lane_res[i];
        sel_cf  = lane_cf[i];
      end
    end
  end

  logic [DW-1:0] q_data;
  srt_hold #(.DW(DW)) i_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   ({sel_res, sel_cf}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (q_data)
  );
  assign out_res = q_data[DW-1:1];
  assign out_cf  = q_data[0];
endmodule

// File: rtl/srt_unit_chk.sv
`timescale 1ns/1ps
module srt_unit_chk #(
  parameter int BASE_W = 8,
  parameter int NUM_SZ = 3,
  parameter int CNT_W  = 5,
  parameter int OP_W   = 4,
  parameter int SZ_W   = 2,
  localparam int MAX_W = BASE_W << (NUM_SZ - 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [OP_W-1:0]  in_op,
  input logic [SZ_W-1:0]  in_size,
  input logic [CNT_W-1:0] in_count,
  input logic [MAX_W-1:0] in_a,
  input logic [MAX_W-1:0] in_b,
  input logic             in_cf,
  input logic             out_valid,
  input logic             out_ready,
  input logic [MAX_W-1:0] out_res,
  input logic             out_cf
);
  logic take, full_w;
  assign take   = in_valid && in_ready;
  assign full_w = int'(in_size) >= NUM_SZ - 1;

  p_ready_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_take_shows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_stall_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res) && $stable(out_cf)));

  p_narrow_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_size == '0) |=> (out_res[MAX_W-1:BASE_W] == '0));

  p_zero_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && full_w && in_count == '0) |=> (out_res == $past(in_a) && out_cf == $past(in_cf)));

  p_unknown_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (take && full_w && int'(in_op) >= 10) |=> (out_res == $past(in_a) && out_cf == $past(in_cf)));
endmodule

bind srt_unit srt_unit_chk #(
  .BASE_W(BASE_W), .NUM_SZ(NUM_SZ), .CNT_W(CNT_W), .OP_W(OP_W), .SZ_W(SZ_W)
) i_srt_unit_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_size(in_size), .in_count(in_count), .in_a(in_a),
  .in_b(in_b), .in_cf(in_cf), .out_valid(out_valid), .out_ready(out_ready),
  .out_res(out_res), .out_cf(out_cf)
);

// File: tb/test_srt_unit.sv
`timescale 1ns/1ps
module test_srt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [1:0]  in_size = '0;
  logic [4:0]  in_count = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        in_cf = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_res;
  logic        out_cf;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  bp_on = 1'b0;
  bit  done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  srt_unit i_srt_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_size(in_size), .in_count(in_count), .in_a(in_a),
    .in_b(in_b), .in_cf(in_cf), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_cf(out_cf)
  );

  typedef struct {
    logic [31:0] r;
    logic        cf;
    logic [3:0]  op;
    logic [4:0]  c;
    logic [1:0]  sz;
  } exp_t;
  exp_t q[$];

  // Bit-serial reference: apply the count one step at a time.
  function automatic void model(input logic [3:0] op, input logic [1:0] sz,
                                input logic [4:0] c, input logic [31:0] a0,
                                input logic [31:0] b0, input logic cin,
                                output logic [31:0] r, output logic cf);
    int w, msb;
    logic [31:0] mask, bb;
    logic t;
    w    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    msb  = w - 1;
    mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    r    = a0 & mask;
    bb   = b0 & mask;
    cf   = cin;
    for (int k = 0; k < int'(c); k++) begin
      case (op)
        4'd0, 4'd9: begin cf = r[msb]; r = (r << 1) & mask; end
        4'd1: begin cf = r[0]; r = r >> 1; end
        4'd2: begin cf = r[0]; r = (r >> 1) | (32'(r[msb]) << msb); end
        4'd3: begin t = r[msb]; r = ((r << 1) | 32'(t)) & mask; cf = t; end
        4'd4: begin t = r[0]; r = (r >> 1) | (32'(t) << msb); cf = t; end
        4'd5: begin t = r[msb]; r = ((r << 1) | 32'(cf)) & mask; cf = t; end
        4'd6: begin t = r[0]; r = (r >> 1) | (32'(cf) << msb); cf = t; end
        4'd7: begin cf = r[msb]; r = ((r << 1) | 32'(bb[msb])) & mask; bb = (bb << 1) & mask; end
        4'd8: begin cf = r[0]; r = (r >> 1) | (32'(bb[0]) << msb); bb = bb >> 1; end
        default: ;
      endcase
    end
  endfunction

  function automatic string tag(input logic [3:0] op, input logic [4:0] c);
    if (c == '0) return "R4";
    case (op)
      4'd0, 4'd9: return "R5";
      4'd1:       return "R6";
      4'd2:       return "R7";
      4'd3, 4'd4: return "R8";
      4'd5, 4'd6: return "R9";
      4'd7:       return "R10";
      4'd8:       return "R11";
      default:    return "R12";
    endcase
  endfunction

  // Back-pressure source.
  initial forever begin
    @(negedge clk);
    out_ready = bp_on ? ($urandom % 4 != 0) : 1'b1;
  end

  // Monitor: looks at the handshakes that the next rising edge will complete.
  bit          stall_prev = 1'b0;
  logic [31:0] res_prev;
  logic        cf_prev;
  initial forever begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      n_chk++;
      if (out_valid !== (q.size() != 0)) begin
        n_fail++;
        $display("FAIL R1 out_valid=%0b expected %0b", out_valid, q.size() != 0);
      end
      if (stall_prev) begin
        n_chk++;
        if (!out_valid || out_res !== res_prev || out_cf !== cf_prev) begin
          n_fail++;
          $display("FAIL R2 held %h/%0b expected %h/%0b", out_res, out_cf, res_prev, cf_prev);
        end
      end
      stall_prev = out_valid && !out_ready;
      res_prev   = out_res;
      cf_prev    = out_cf;
      if (out_valid && out_ready && q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (out_res !== e.r || out_cf !== e.cf) begin
          n_fail++;
          $display("FAIL %s op=%0d sz=%0d c=%0d got %h/%0b expected %h/%0b",
                   tag(e.op, e.c), e.op, e.sz, e.c, out_res, out_cf, e.r, e.cf);
        end
        if (e.sz < 2'd2) begin
          n_chk++;
          if (out_res[31:16] !== 16'h0 || (e.sz == 2'd0 && out_res[15:8] !== 8'h0)) begin
            n_fail++;
            $display("FAIL R3 upper bits got %h expected %h", out_res, e.r);
          end
        end
      end
      if (in_valid && in_ready) begin
        exp_t e;
        model(in_op, in_size, in_count, in_a, in_b, in_cf, e.r, e.cf);
        e.op = in_op; e.c = in_count; e.sz = in_size;
        q.push_back(e);
      end
    end
  end

  task automatic send(input logic [3:0] op, input logic [1:0] sz, input logic [4:0] c,
                      input logic [31:0] a, input logic [31:0] b, input logic cin);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_size = sz; in_count = c;
    in_a = a; in_b = b; in_cf = cin;
    #3;
    while (!in_ready) begin
      @(negedge clk);
      #3;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    n_chk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset out_valid=%0b in_ready=%0b expected 0 1", out_valid, in_ready);
    end
    // Worked examples from the requirements.
    send(4'd0, 2'd0, 5'd1, 32'h8F, 32'h0, 1'b0);        // R5
    send(4'd9, 2'd0, 5'd1, 32'h8F, 32'h0, 1'b0);        // R5 alias
    send(4'd1, 2'd0, 5'd1, 32'hD0, 32'h0, 1'b1);        // R6
    send(4'd2, 2'd0, 5'd1, 32'hF0, 32'h0, 1'b1);        // R7
    send(4'd2, 2'd0, 5'd3, 32'h80, 32'h0, 1'b0);        // R7
    send(4'd3, 2'd0, 5'd3, 32'h40, 32'h0, 1'b0);        // R8
    send(4'd4, 2'd0, 5'd1, 32'h01, 32'h0, 1'b0);        // R8
    send(4'd3, 2'd0, 5'd8, 32'hA5, 32'h0, 1'b0);        // R8 full turn
    send(4'd5, 2'd0, 5'd1, 32'h88, 32'h0, 1'b0);        // R9
    send(4'd5, 2'd0, 5'd1, 32'h10, 32'h0, 1'b1);        // R9
    send(4'd6, 2'd0, 5'd2, 32'h10, 32'h0, 1'b1);        // R9
    send(4'd5, 2'd0, 5'd9, 32'h3C, 32'h0, 1'b1);        // R9 full turn
    send(4'd7, 2'd1, 5'd4, 32'h9BA6, 32'hAC36, 1'b0);   // R10
    send(4'd8, 2'd1, 5'd4, 32'h234B, 32'h7654, 1'b0);   // R11
    send(4'd7, 2'd0, 5'd20, 32'hC3, 32'h5A, 1'b1);      // R10 past 2w
    send(4'd8, 2'd2, 5'd31, 32'h8000_0001, 32'hFFFF_0000, 1'b0); // R11
    send(4'd0, 2'd0, 5'd9, 32'hFF, 32'h0, 1'b1);        // R5 c > w
    send(4'd1, 2'd1, 5'd17, 32'hFFFF, 32'h0, 1'b1);     // R6 c > w
    send(4'd2, 2'd0, 5'd12, 32'h80, 32'h0, 1'b0);       // R7 c > w
    send(4'd3, 2'd2, 5'd0, 32'h1234_5678, 32'h0, 1'b1); // R4
    send(4'd12, 2'd3, 5'd7, 32'hCAFE_F00D, 32'h0, 1'b1); // R12
    send(4'd0, 2'd0, 5'd1, 32'hFFFF_FF81, 32'h0, 1'b0); // R3 upper ignored
    idle(3);
    // Random traffic with back-pressure.
    bp_on = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] c;
      c = ($urandom % 3 == 0) ? 5'($urandom % 3) : 5'($urandom);
      send(4'($urandom), 2'($urandom), c, $urandom, $urandom, 1'($urandom));
      if ($urandom % 8 == 0) idle(1);
    end
    idle(4);
    bp_on = 1'b0;
    idle(4);
    n_chk++;
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 results left pending %0d expected 0", q.size());
    end
    finish_run();
  end
endmodule